// File: doc/BRIEF.md
# Floating-Point Status and Control Register

A 64-bit register holding the floating-point exception flags, result flags and control modes of a floating-point unit. Bit numbering is big-endian: bit 0 is the most significant bit of the word and bit 63 the least significant. A port may write the whole word at once. Separate ports write only the exception group, only the result-flag group, or only the control group. A sticky port lets execution units OR newly detected exception causes into the register without clearing any cause that is already set.

The invalid-operation summary and the enabled-exception summary are not stored. They are derived combinationally from the stored causes and enables, so any value written to those two positions is discarded. The exception summary FX is an ordinary stored bit. It changes only when a write places a value in it, or when the sticky port raises a cause that was clear. The block also decodes the control fields onto their own outputs: binary rounding mode, decimal rounding mode, non-IEEE mode and the five trap enables.

Field positions (MSB0):
- DRN: 29..31
- FX: 32
- FEX: 33
- VX: 34
- OX, UX, ZX, XX: 35..38
- Invalid causes: 39..44 and 53..55
- FR: 45
- FI: 46
- Class: 47
- FL, FG, FE, FU: 48..51
- VE, OE, UE, ZE, XE: 56..60
- NI: 61
- RN: 62..63

Reserved bits are 0..28 and 52.

Top module: `fp_status_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every stored bit. `fpscr_q` then reads all zeros, including both derived summary bits.
- R2: A full-word write (`wr_all_en`) loads every writable bit from `wr_all_data[63-n]` for MSB0 bit n. Reserved bits 0..28 and 52 always read as zero, whatever is written to them.
- R3: VX (MSB0 34) always equals the OR of the nine invalid-operation causes (MSB0 39..44 and 53..55). A value written to that position is ignored.
- R4: FEX (MSB0 33) always equals (VX&VE)|(OX&OE)|(UX&UE)|(ZX&ZE)|(XX&XE), with enables VE..XE at MSB0 56..60. A value written to that position is ignored.
- R5: FX (MSB0 32) is held unless one of three things happens: a full-word write, an exception-group write, or a sticky update that raises a previously clear cause.
- R6: An exception-group write (`exc_wr_en`) loads the 13 cause bits from `exc_wr_val` and loads FX from `exc_wr_fx`. Index k maps to MSB0 35+k for k = 0..9 (OX, UX, ZX, XX, SNaN, inf-inf, inf/inf, 0/0, inf*0, invalid compare). Index k maps to MSB0 43+k for k = 10..12 (software, square root, integer convert).
- R7: A result-flag write (`res_wr_en`) loads MSB0 45..51 from `res_wr_val`. Index k goes to MSB0 51-k: FU is index 0 and FR is index 6.
- R8: A control write (`ctl_wr_en`) loads MSB0 29..31 and 56..63 from `ctl_wr_val`, as follows:
  - `ctl_wr_val[10:8]` is DRN, with bit 8 at MSB0 31.
  - `ctl_wr_val[7:3]` is VE, OE, UE, ZE, XE.
  - `ctl_wr_val[2]` is NI.
  - `ctl_wr_val[1:0]` is RN, with bit 0 at MSB0 63.

  The decoded outputs always mirror the register: `rnd_mode`, `dec_rnd_mode`, `non_ieee`, and `exc_enables` (VE in bit 4 down to XE in bit 0).
- R9: A sticky update (`stk_en`) ORs `stk_bits` (same index map as R6) into the causes and never clears one. If any cause goes from 0 to 1, FX is set at the same edge.
- R10: When several writes occur together, they apply in this order: the full-word write first, then the group writes replace their own fields, then the sticky OR is applied on top. The result becomes visible after one clock edge.
- R11: A sticky update whose bits are all already set leaves FX unchanged, including an FX that software has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_all_en | input | 1 | Full-word write strobe |
| wr_all_data | input | 64 | Full-word write data, MSB0 bit n in index 63-n |
| exc_wr_en | input | 1 | Exception-group write strobe |
| exc_wr_val | input | 13 | Cause values for the exception-group write |
| exc_wr_fx | input | 1 | FX value for the exception-group write |
| res_wr_en | input | 1 | Result-flag write strobe |
| res_wr_val | input | 7 | FR, FI, class, FL, FG, FE, FU (index 6 down to 0) |
| ctl_wr_en | input | 1 | Control-group write strobe |
| ctl_wr_val | input | 11 | DRN, five enables, NI, RN |
| stk_en | input | 1 | Sticky cause OR-in strobe |
| stk_bits | input | 13 | Causes to OR in |
| fpscr_q | output | 64 | Register value including derived summaries |
| rnd_mode | output | 2 | Binary rounding mode |
| dec_rnd_mode | output | 3 | Decimal rounding mode |
| non_ieee | output | 1 | Non-IEEE mode |
| exc_enables | output | 5 | VE, OE, UE, ZE, XE (bit 4 down to 0) |

## Verification
The hold assertions assume that a field can only change through its own group port, the full-word port, or the sticky port. They therefore check stability only in cycles where none of those strobes touches the field in question. The sticky-accumulation property assumes that no cause-writing strobe coincides with the sticky strobe, and its antecedent excludes those cycles. The bench deliberately mixes every strobe in a randomized phase, so that the priority order is also exercised, while directed phases isolate each port. A mid-run reset exercises the reset path while the register holds non-zero state.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
   localparam int REG_W   = 64;
   localparam int N_CAUSE = 13;
   localparam int N_RES   = 7;
   localparam int N_CTL   = 11;
   localparam int N_EN    = 5;

   localparam int FX_MSB0  = 32;
   localparam int FEX_MSB0 = 33;
   localparam int VX_MSB0  = 34;
   localparam int FIRST_INV_CAUSE = 4;

   typedef struct packed {
      logic [2:0] drn;
      logic [4:0] en;
      logic       ni;
      logic [1:0] rn;
   } ctl_fields_t;

   // Convert a big-endian bit number into a vector index.
   function automatic int lsb(input int msb0);
      return REG_W - 1 - msb0;
   endfunction

   // MSB0 location of cause index k.
   function automatic int cause_msb0(input int k);
      return (k < 10) ? 35 + k : 43 + k;
   endfunction

   // Bits that storage may hold (reserved and derived bits excluded).
   function automatic logic [REG_W-1:0] store_mask();
      logic [REG_W-1:0] m;
      m = '0;
      for (int b = 29; b < REG_W; b++)
         if (b != FEX_MSB0 && b != VX_MSB0 && b != 52)
            m[lsb(b)] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/fpsc_merge.sv
module fpsc_merge
   import fpsc_pkg::*;
#(
   parameter int W  = REG_W,
   parameter int NC = N_CAUSE
) (
   input  logic [W-1:0]     cur,
   input  logic             wr_all_en,
   input  logic [W-1:0]     wr_all_data,
   input  logic             exc_wr_en,
   input  logic [NC-1:0]    exc_wr_val,
   input  logic             exc_wr_fx,
   input  logic             res_wr_en,
   input  logic [N_RES-1:0] res_wr_val,
   input  logic             ctl_wr_en,
   input  ctl_fields_t      ctl_wr_val,
   input  logic             stk_en,
   input  logic [NC-1:0]    stk_bits,
   output logic [W-1:0]     nxt
);
   localparam logic [W-1:0] KEEP = store_mask();

   always_comb begin
      logic [W-1:0] s;
      logic         fresh;
      s     = wr_all_en ? (wr_all_data & KEEP) : cur;
      fresh = 1'b0;
      if (exc_wr_en) begin
         for (int k = 0; k < NC; k++)
            s[lsb(cause_msb0(k))] = exc_wr_val[k];
         s[lsb(FX_MSB0)] = exc_wr_fx;
      end
      if (res_wr_en)
         for (int k = 0; k < N_RES; k++)
            s[lsb(51 - k)] = res_wr_val[k];
      if (ctl_wr_en) begin
         for (int k = 0; k < 2; k++)
            s[lsb(63 - k)] = ctl_wr_val.rn[k];
         s[lsb(61)] = ctl_wr_val.ni;
         for (int k = 0; k < N_EN; k++)
            s[lsb(60 - k)] = ctl_wr_val.en[k];
         for (int k = 0; k < 3; k++)
            s[lsb(31 - k)] = ctl_wr_val.drn[k];
      end
      if (stk_en) begin
         for (int k = 0; k < NC; k++) begin
            if (stk_bits[k] && !s[lsb(cause_msb0(k))])
               fresh = 1'b1;
            s[lsb(cause_msb0(k))] = s[lsb(cause_msb0(k))] | stk_bits[k];
         end
         if (fresh)
            s[lsb(FX_MSB0)] = 1'b1;
      end
      nxt = s;
   end
endmodule

// File: rtl/fpsc_summary.sv
module fpsc_summary
   import fpsc_pkg::*;
#(
   parameter int W  = REG_W,
   parameter int NC = N_CAUSE
) (
   input  logic [W-1:0] word,
   output logic         vx,
   output logic         fex
);
   logic [NC-1:0] cause;

   for (genvar k = 0; k < NC; k++) begin : g_cause
      assign cause[k] = word[lsb(cause_msb0(k))];
   end

   assign vx  = |cause[NC-1:FIRST_INV_CAUSE];
   assign fex = (vx       & word[lsb(56)]) |
                (cause[0] & word[lsb(57)]) |
                (cause[1] & word[lsb(58)]) |
                (cause[2] & word[lsb(59)]) |
                (cause[3] & word[lsb(60)]);
endmodule

// File: rtl/fpsc_decode.sv
module fpsc_decode
   import fpsc_pkg::*;
#(
   parameter int W = REG_W
) (
   input  logic [W-1:0]    word,
   output logic [1:0]      rnd_mode,
   output logic [2:0]      dec_rnd_mode,
   output logic            non_ieee,
   output logic [N_EN-1:0] exc_enables
);
   assign rnd_mode     = {word[lsb(62)], word[lsb(63)]};
   assign dec_rnd_mode = {word[lsb(29)], word[lsb(30)], word[lsb(31)]};
   assign non_ieee     = word[lsb(61)];

   for (genvar k = 0; k < N_EN; k++) begin : g_en
      assign exc_enables[k] = word[lsb(60 - k)];
   end
endmodule

// File: rtl/fp_status_ctl.sv
module fp_status_ctl
   import fpsc_pkg::*;
#(
   parameter int WORD_W    = REG_W,
   parameter int CAUSE_CNT = N_CAUSE
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_all_en,
   input  logic [WORD_W-1:0]    wr_all_data,
   input  logic                 exc_wr_en,
   input  logic [CAUSE_CNT-1:0] exc_wr_val,
   input  logic                 exc_wr_fx,
   input  logic                 res_wr_en,
   input  logic [N_RES-1:0]     res_wr_val,
   input  logic                 ctl_wr_en,
   input  logic [N_CTL-1:0]     ctl_wr_val,
   input  logic                 stk_en,
   input  logic [CAUSE_CNT-1:0] stk_bits,
   output logic [WORD_W-1:0]    fpscr_q,
   output logic [1:0]           rnd_mode,
   output logic [2:0]           dec_rnd_mode,
   output logic                 non_ieee,
   output logic [N_EN-1:0]      exc_enables
);
   localparam logic [WORD_W-1:0] RSVD = ~(store_mask() |
      (64'd1 << lsb(VX_MSB0)) | (64'd1 << lsb(FEX_MSB0)));

   if (WORD_W != REG_W) begin : g_bad_width
      $error("fp_status_ctl: WORD_W must be 64");
   end
   if (CAUSE_CNT != N_CAUSE) begin : g_bad_causes
      $error("fp_status_ctl: CAUSE_CNT must be 13");
   end

   logic [WORD_W-1:0] stored;
   logic [WORD_W-1:0] nxt;
   logic              vx;
   logic              fex;

   fpsc_merge #(.W(WORD_W), .NC(CAUSE_CNT)) u_merge (
      .cur        (stored),
      .wr_all_en  (wr_all_en),
      .wr_all_data(wr_all_data),
      .exc_wr_en  (exc_wr_en),
      .exc_wr_val (exc_wr_val),
      .exc_wr_fx  (exc_wr_fx),
      .res_wr_en  (res_wr_en),
      .res_wr_val (res_wr_val),
      .ctl_wr_en  (ctl_wr_en),
      .ctl_wr_val (ctl_fields_t'(ctl_wr_val)),
      .stk_en     (stk_en),
      .stk_bits   (stk_bits),
      .nxt        (nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) stored <= '0;
      else     stored <= nxt;
   end

   fpsc_summary #(.W(WORD_W), .NC(CAUSE_CNT)) u_summary (
      .word(stored),
      .vx  (vx),
      .fex (fex)
   );

   always_comb begin
      fpscr_q                = stored;
      fpscr_q[lsb(VX_MSB0)]  = vx;
      fpscr_q[lsb(FEX_MSB0)] = fex;
   end

   fpsc_decode #(.W(WORD_W)) u_decode (
      .word        (stored),
      .rnd_mode    (rnd_mode),
      .dec_rnd_mode(dec_rnd_mode),
      .non_ieee    (non_ieee),
      .exc_enables (exc_enables)
   );

   logic [CAUSE_CNT-1:0] cause_q;
   for (genvar k = 0; k < CAUSE_CNT; k++) begin : g_cq
      assign cause_q[k] = fpscr_q[lsb(cause_msb0(k))];
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk) rst |=> fpscr_q == '0);

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (fpscr_q & RSVD) == '0);

   // R4
   fex_cause_chk: assert property (@(posedge clk) disable iff (rst)
      fpscr_q[lsb(FEX_MSB0)] |-> (fpscr_q[lsb(VX_MSB0)] | (|cause_q[3:0])));

   // R5
   fx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_all_en && !exc_wr_en && !stk_en) |=> $stable(fpscr_q[lsb(FX_MSB0)]));

   // R8
   ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_all_en && !ctl_wr_en) |=>
      $stable({dec_rnd_mode, exc_enables, non_ieee, rnd_mode}));

   // R9
   sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (stk_en && !wr_all_en && !exc_wr_en) |=>
      ((cause_q & $past(cause_q | stk_bits)) == $past(cause_q | stk_bits)));

   // R9
   fx_raise_chk: assert property (@(posedge clk) disable iff (rst)
      (stk_en && !wr_all_en && !exc_wr_en && ((stk_bits & ~cause_q) != '0))
      |=> fpscr_q[lsb(FX_MSB0)]);
endmodule

// File: tb/test_fp_status_ctl.sv
`timescale 1ns/1ps
module test_fp_status_ctl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_all_en = 1'b0;
   logic [63:0] wr_all_data = '0;
   logic        exc_wr_en = 1'b0;
   logic [12:0] exc_wr_val = '0;
   logic        exc_wr_fx = 1'b0;
   logic        res_wr_en = 1'b0;
   logic [6:0]  res_wr_val = '0;
   logic        ctl_wr_en = 1'b0;
   logic [10:0] ctl_wr_val = '0;
   logic        stk_en = 1'b0;
   logic [12:0] stk_bits = '0;
   logic [63:0] fpscr_q;
   logic [1:0]  rnd_mode;
   logic [2:0]  dec_rnd_mode;
   logic        non_ieee;
   logic [4:0]  exc_enables;

   always #2.5 clk = ~clk;

   fp_status_ctl i_fp_status_ctl (
      .clk(clk), .rst(rst),
      .wr_all_en(wr_all_en), .wr_all_data(wr_all_data),
      .exc_wr_en(exc_wr_en), .exc_wr_val(exc_wr_val), .exc_wr_fx(exc_wr_fx),
      .res_wr_en(res_wr_en), .res_wr_val(res_wr_val),
      .ctl_wr_en(ctl_wr_en), .ctl_wr_val(ctl_wr_val),
      .stk_en(stk_en), .stk_bits(stk_bits),
      .fpscr_q(fpscr_q), .rnd_mode(rnd_mode), .dec_rnd_mode(dec_rnd_mode),
      .non_ieee(non_ieee), .exc_enables(exc_enables)
   );

   int    vectors = 0;
   int    errors  = 0;
   bit    done    = 0;
   string cur_req = "R1";
   logic [63:0] mdl = '0;

   function automatic int cpos(input int k);
      return (k < 10) ? 35 + k : 43 + k;
   endfunction

   function automatic bit gb(input logic [63:0] w, input int n);
      return w[63 - n];
   endfunction

   function automatic logic [63:0] sb(input logic [63:0] w, input int n, input bit v);
      logic [63:0] r;
      r = w;
      r[63 - n] = v;
      return r;
   endfunction

   function automatic logic [63:0] with_summary(input logic [63:0] w);
      bit inv, en_hit;
      logic [63:0] r;
      inv = 0;
      for (int k = 4; k < 13; k++) inv |= gb(w, cpos(k));
      en_hit = (inv & gb(w, 56)) | (gb(w, 35) & gb(w, 57)) | (gb(w, 36) & gb(w, 58))
             | (gb(w, 37) & gb(w, 59)) | (gb(w, 38) & gb(w, 60));
      r = sb(w, 34, inv);
      r = sb(r, 33, en_hit);
      return r;
   endfunction

   always @(posedge clk) begin
      logic [63:0] n;
      bit rise;
      if (rst) mdl = '0;
      else begin
         n = mdl;
         if (wr_all_en) begin
            n = '0;
            for (int b = 29; b < 64; b++)
               if (b != 33 && b != 34 && b != 52) n = sb(n, b, gb(wr_all_data, b));
         end
         if (exc_wr_en) begin
            for (int k = 0; k < 13; k++) n = sb(n, cpos(k), exc_wr_val[k]);
            n = sb(n, 32, exc_wr_fx);
         end
         if (res_wr_en)
            for (int k = 0; k < 7; k++) n = sb(n, 51 - k, res_wr_val[k]);
         if (ctl_wr_en) begin
            n = sb(n, 29, ctl_wr_val[10]); n = sb(n, 30, ctl_wr_val[9]);
            n = sb(n, 31, ctl_wr_val[8]);
            for (int k = 0; k < 5; k++) n = sb(n, 56 + k, ctl_wr_val[7 - k]);
            n = sb(n, 61, ctl_wr_val[2]);
            n = sb(n, 62, ctl_wr_val[1]); n = sb(n, 63, ctl_wr_val[0]);
         end
         if (stk_en) begin
            rise = 0;
            for (int k = 0; k < 13; k++)
               if (stk_bits[k]) begin
                  if (!gb(n, cpos(k))) rise = 1;
                  n = sb(n, cpos(k), 1'b1);
               end
            if (rise) n = sb(n, 32, 1'b1);
         end
         mdl = n;
      end
   end

   task automatic compare();
      logic [63:0] e;
      logic [1:0] e_rn;
      logic [2:0] e_drn;
      logic [4:0] e_en;
      e = with_summary(mdl);
      e_rn = {gb(e, 62), gb(e, 63)};
      e_drn = {gb(e, 29), gb(e, 30), gb(e, 31)};
      for (int k = 0; k < 5; k++) e_en[4 - k] = gb(e, 56 + k);
      vectors++;
      if (fpscr_q !== e || rnd_mode !== e_rn || dec_rnd_mode !== e_drn ||
          non_ieee !== gb(e, 61) || exc_enables !== e_en) begin
         errors++;
         $display("FAIL %s: word=%h rn=%b drn=%b ni=%b en=%b expected word=%h rn=%b drn=%b ni=%b en=%b",
                  cur_req, fpscr_q, rnd_mode, dec_rnd_mode, non_ieee, exc_enables,
                  e, e_rn, e_drn, gb(e, 61), e_en);
      end
   endtask

   task automatic idle();
      wr_all_en = 0; exc_wr_en = 0; res_wr_en = 0; ctl_wr_en = 0; stk_en = 0;
   endtask

   task automatic tick(input string tag);
      cur_req = tag;
      @(negedge clk);
      compare();
      idle();
   endtask

   task automatic full_wr(input logic [63:0] d, input string tag);
      wr_all_en = 1; wr_all_data = d; tick(tag);
   endtask

   function automatic logic [63:0] only(input int n);
      return sb(64'd0, n, 1'b1);
   endfunction

   initial begin
      tick("R1"); tick("R1");
      rst = 0;
      tick("R1");
      full_wr('1, "R2");
      tick("R2");
      full_wr(only(34) | only(33), "R3");
      full_wr(only(53), "R3");
      full_wr(only(44) | only(56), "R4");
      full_wr(only(35) | only(57), "R4");
      full_wr(only(36) | only(60), "R4");
      full_wr(only(38) | only(60), "R4");
      full_wr(only(37) | only(59) | only(33), "R4");
      full_wr(only(32), "R5");
      res_wr_en = 1; res_wr_val = 7'h55; tick("R5");
      ctl_wr_en = 1; ctl_wr_val = 11'h7ff; tick("R5");
      exc_wr_en = 1; exc_wr_val = 13'h1001; exc_wr_fx = 0; tick("R6");
      exc_wr_en = 1; exc_wr_val = 13'h0aaa; exc_wr_fx = 1; tick("R6");
      res_wr_en = 1; res_wr_val = 7'h2a; tick("R7");
      res_wr_en = 1; res_wr_val = 7'h01; tick("R7");
      ctl_wr_en = 1; ctl_wr_val = 11'b101_10010_1_01; tick("R8");
      ctl_wr_en = 1; ctl_wr_val = 11'b010_01101_0_10; tick("R8");
      exc_wr_en = 1; exc_wr_val = 13'h0; exc_wr_fx = 0; tick("R9");
      stk_en = 1; stk_bits = 13'h0008; tick("R9");
      stk_en = 1; stk_bits = 13'h1400; tick("R9");
      exc_wr_en = 1; exc_wr_val = 13'h1408; exc_wr_fx = 0; tick("R11");
      stk_en = 1; stk_bits = 13'h1008; tick("R11");
      stk_en = 1; stk_bits = 13'h0000; tick("R11");
      wr_all_en = 1; wr_all_data = only(35);
      exc_wr_en = 1; exc_wr_val = 13'h0004; exc_wr_fx = 0;
      stk_en = 1; stk_bits = 13'h0002; tick("R10");
      wr_all_en = 1; wr_all_data = '1;
      res_wr_en = 1; res_wr_val = 7'h00;
      ctl_wr_en = 1; ctl_wr_val = 11'h000; tick("R10");
      for (int i = 0; i < 400; i++) begin
         wr_all_en  = ($urandom_range(0, 7) == 0);
         wr_all_data = {$urandom, $urandom};
         exc_wr_en  = ($urandom_range(0, 5) == 0);
         exc_wr_val = 13'($urandom);
         exc_wr_fx  = 1'($urandom);
         res_wr_en  = ($urandom_range(0, 3) == 0);
         res_wr_val = 7'($urandom);
         ctl_wr_en  = ($urandom_range(0, 4) == 0);
         ctl_wr_val = 11'($urandom);
         stk_en     = ($urandom_range(0, 2) == 0);
         stk_bits   = 13'(1 << $urandom_range(0, 12));
         rst        = (i == 200);
         tick("R10");
      end
      rst = 0;
      tick("R1");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule